// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Wake-Up Filter

This block receives asynchronous serial characters in which a ninth, multiprocessor bit follows the eight data bits. The line idles high. Each frame is one start bit, eight data bits with the least significant bit first, the multiprocessor bit and one stop bit. A clock enable at sixteen times the bit rate paces the receiver. A start bit counts only if the line is still low at the middle of the bit. Every later bit is sampled once, at its middle.

Software uses a small register port. One write loads the control bits: receiver enable, multiprocessor mode and the wake-up filter. A second write clears status flags, where a 0 clears a flag and a 1 leaves it as it is. The received character, its multiprocessor bit, the flags and the control bits are always visible on output ports.

In a multi-drop network a node sets the filter and then sleeps through traffic meant for other nodes. When multiprocessor mode is on and the filter is set, a frame whose multiprocessor bit is 0 is discarded without leaving any trace. The first frame whose multiprocessor bit is 1 clears the filter in hardware and is received as an ordinary character.

Top module: `mpuart_rx`

## Requirements
- R1: After reset the control readback is 0, the data register is 0, and the data-full, framing-error and overrun flags are 0.
- R2: While the enable bit (ctl bit 0) is 0, the serial line is ignored: no frame changes the data register or any flag.
- R3: Clearing the enable bit leaves the data-full, framing-error and overrun flags and the data register unchanged.
- R4: A low pulse shorter than half a bit is not taken as a start bit. The receiver goes back to waiting, and a following frame is received correctly.
- R5: A frame that is accepted, has a stop bit of 1 and arrives while data-full is 0 loads its data bits (the first bit received is data bit 0) into the data register and its multiprocessor bit into rx_mpb, and sets data-full.
- R6: An accepted frame with a stop bit of 0 sets framing-error and leaves the data register and data-full unchanged.
- R7: An accepted frame with a stop bit of 1 that completes while data-full is 1 sets overrun and leaves the data register unchanged.
- R8: With multiprocessor mode (ctl bit 1) and the filter (ctl bit 2) both set, a frame whose multiprocessor bit is 0 changes no flag and not the data register, even when its stop bit is 0.
- R9: With multiprocessor mode and the filter set, a frame whose multiprocessor bit is 1 clears the filter bit and is then handled as in R5 to R7. Frames after it are received without filtering.
- R10: With multiprocessor mode off, the filter bit has no effect. Frames with either multiprocessor bit value are received, and the filter bit is not cleared.
- R11: A status write clears each flag whose bit in the written value is 0 (bit 0 data-full, bit 1 framing-error, bit 2 overrun) and leaves each flag whose bit is 1.
- R12: A filter bit written while a frame is in progress applies to that frame when it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Enable at 16x the bit rate |
| rxd | input | 1 | Serial input, idles high |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control value: bit 0 enable, bit 1 multiprocessor mode, bit 2 filter |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 3 | Flag keep mask: a 0 clears, bit 0 full, bit 1 framing, bit 2 overrun |
| ctl_q | output | 3 | Control bits read back |
| rx_data | output | 8 | Data register |
| rx_mpb | output | 1 | Multiprocessor bit of the held character |
| rx_full | output | 1 | Data-full flag |
| rx_ferr | output | 1 | Framing-error flag |
| rx_ovr | output | 1 | Overrun flag |

## Verification
The assertions assume that rxd changes slowly compared with os_tick, so each bit stays stable for sixteen ticks. They also assume that a status write is never issued while the receiver is disabled and a flag is expected to hold. The bench keeps os_tick high on every cycle. It changes rxd only at falling clock edges and holds each bit for exactly sixteen cycles. It issues register writes as single-cycle pulses, with the receiver idle or, for the mid-frame filter case, well away from the bit that completes the frame.

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  input  logic              sts_we,
  input  logic [2:0]        sts_wdata,
  output logic [2:0]        ctl_q,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_full,
  output logic              rx_ferr,
  output logic              rx_ovr
);
  localparam int CW    = $clog2(OSR);
  localparam int NBITS = DATA_W + 2;
  localparam int IW    = $clog2(NBITS + 1);
  localparam logic [CW-1:0] HALF = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [IW-1:0] STOP = IW'(NBITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DATA_W:0] sh;
  logic [1:0]    sync;
  logic          rx_en, mp_mode, wake_filt;

  wire rxd_s  = sync[1];
  wire done   = rx_en && os_tick && st == S_BITS && cnt == LAST && idx == STOP;
  wire fmpb   = sh[DATA_W];
  wire filt_on = mp_mode & wake_filt;
  wire keep   = done & ~(filt_on & ~fmpb);
  wire take   = keep & rxd_s & ~rx_full;
  wire ovr_set = keep & rxd_s & rx_full;
  wire fe_set = keep & ~rxd_s;
  wire wake   = done & filt_on & fmpb;

  assign ctl_q = {wake_filt, mp_mode, rx_en};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else if (!rx_en) begin
      st <= S_IDLE;
    end else if (os_tick) begin
      case (st)
        S_IDLE:
          if (!rxd_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (cnt == HALF) begin
            cnt <= '0;
            idx <= '0;
            st  <= rxd_s ? S_IDLE : S_BITS;
          end else cnt <= cnt + 1'b1;
        S_BITS:
          if (cnt == LAST) begin
            cnt <= '0;
            if (idx == STOP) st <= S_IDLE;
            else begin
              sh  <= {rxd_s, sh[DATA_W:1]};
              idx <= idx + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en     <= 1'b0;
      mp_mode   <= 1'b0;
      wake_filt <= 1'b0;
    end else if (ctl_we) begin
      {wake_filt, mp_mode, rx_en} <= ctl_wdata;
    end else if (wake) begin
      wake_filt <= 1'b0;
    end
  end

  wire [2:0] keep_m = sts_we ? sts_wdata : 3'b111;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_mpb  <= 1'b0;
      rx_full <= 1'b0;
      rx_ferr <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (take) begin
        rx_data <= sh[DATA_W-1:0];
        rx_mpb  <= fmpb;
      end
      rx_full <= take    | (rx_full & keep_m[0]);
      rx_ferr <= fe_set  | (rx_ferr & keep_m[1]);
      rx_ovr  <= ovr_set | (rx_ovr  & keep_m[2]);
    end
  end

  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> st == S_IDLE);

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !sts_we) |=> $stable({rx_full, rx_ferr, rx_ovr, rx_data}));

  p_fe_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ferr) |-> $stable(rx_data));

  p_ovr_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $stable(rx_data));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> !($past(mp_mode && wake_filt) && !rx_mpb));

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wake_filt) && !$past(ctl_we)) |-> $past(mp_mode && rx_en));

  p_one_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(rx_full) && $rose(rx_ovr)));
endmodule

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb;
  logic clk = 0, rst_n = 0, os_tick = 1, rxd = 1;
  logic ctl_we = 0, sts_we = 0;
  logic [2:0] ctl_wdata = 0, sts_wdata = 0;
  logic [2:0] ctl_q;
  logic [7:0] rx_data;
  logic rx_mpb, rx_full, rx_ferr, rx_ovr;
  int nchk = 0, nfail = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  mpuart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .ctl_q(ctl_q), .rx_data(rx_data), .rx_mpb(rx_mpb),
    .rx_full(rx_full), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags(string req, logic [2:0] exp);
    chk(req, {5'b0, rx_ovr, rx_ferr, rx_full}, {5'b0, exp});
  endtask

  task automatic wr_ctl(logic [2:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_sts(logic [2:0] v);
    @(negedge clk); sts_we = 1; sts_wdata = v;
    @(negedge clk); sts_we = 0;
  endtask

  task automatic send(logic [7:0] d, logic mpb, logic stp);
    logic [10:0] fr;
    fr = {stp, mpb, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); rxd = fr[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rxd = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ctl", {5'b0, ctl_q}, 8'h00);
    chk("R1 data", rx_data, 8'h00);
    chk_flags("R1 flags", 3'b000);
  endtask

  task automatic t_basic;
    wr_ctl(3'b001);
    send(8'hA5, 0, 1);
    chk("R5 data", rx_data, 8'hA5);
    chk("R5 mpb", {7'b0, rx_mpb}, 8'h00);
    chk_flags("R5 flags", 3'b001);
    wr_sts(3'b000);
    send(8'h3C, 1, 1);
    chk("R5 data2", rx_data, 8'h3C);
    chk("R5 mpb2", {7'b0, rx_mpb}, 8'h01);
  endtask

  task automatic t_clear;
    wr_sts(3'b111);
    chk_flags("R11 keep", 3'b001);
    wr_sts(3'b110);
    chk_flags("R11 clear", 3'b000);
  endtask

  task automatic t_ovr;
    send(8'h10, 0, 1);
    send(8'h11, 0, 1);
    chk("R7 data", rx_data, 8'h10);
    chk_flags("R7 flags", 3'b101);
    wr_sts(3'b000);
  endtask

  task automatic t_fe;
    send(8'h77, 0, 0);
    chk("R6 data", rx_data, 8'h10);
    chk_flags("R6 flags", 3'b010);
    wr_sts(3'b000);
  endtask

  task automatic t_glitch;
    @(negedge clk); rxd = 0;
    repeat (5) @(negedge clk);
    rxd = 1;
    repeat (100) @(negedge clk);
    chk_flags("R4 glitch", 3'b000);
    send(8'h5A, 0, 1);
    chk("R4 after", rx_data, 8'h5A);
    wr_sts(3'b000);
  endtask

  task automatic t_filter;
    wr_ctl(3'b111);
    send(8'h22, 0, 1);
    chk_flags("R8 drop", 3'b000);
    chk("R8 data", rx_data, 8'h5A);
    send(8'h23, 0, 0);
    chk_flags("R8 drop fe", 3'b000);
    chk("R8 ctl", {5'b0, ctl_q}, 8'h07);
    send(8'h81, 1, 1);
    chk("R9 data", rx_data, 8'h81);
    chk("R9 mpb", {7'b0, rx_mpb}, 8'h01);
    chk("R9 ctl", {5'b0, ctl_q}, 8'h03);
    send(8'h44, 0, 1);
    chk_flags("R9 after", 3'b101);
    wr_sts(3'b000);
  endtask

  task automatic t_nomp;
    wr_ctl(3'b101);
    send(8'h66, 0, 1);
    chk("R10 data", rx_data, 8'h66);
    chk_flags("R10 flags", 3'b001);
    wr_sts(3'b000);
    send(8'h99, 1, 1);
    chk("R10 data2", rx_data, 8'h99);
    chk("R10 ctl", {5'b0, ctl_q}, 8'h05);
    wr_sts(3'b000);
  endtask

  task automatic t_midframe;
    wr_ctl(3'b011);
    fork
      send(8'h33, 0, 1);
      begin
        repeat (80) @(negedge clk);
        ctl_we = 1; ctl_wdata = 3'b111;
        @(negedge clk); ctl_we = 0;
      end
    join
    chk_flags("R12 drop", 3'b000);
    chk("R12 data", rx_data, 8'h99);
    chk("R12 ctl", {5'b0, ctl_q}, 8'h07);
  endtask

  task automatic t_off;
    wr_ctl(3'b011);
    send(8'hC3, 0, 1);
    send(8'h0F, 0, 0);
    chk_flags("R3 pre", 3'b011);
    wr_ctl(3'b000);
    chk_flags("R3 hold", 3'b011);
    chk("R3 data", rx_data, 8'hC3);
    send(8'hFF, 0, 1);
    send(8'h00, 0, 0);
    chk_flags("R2 flags", 3'b011);
    chk("R2 data", rx_data, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_clear;
    t_ovr;
    t_fe;
    t_glitch;
    t_filter;
    t_nomp;
    t_midframe;
    t_off;
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule